// File: doc/BRIEF.md
# Half-Band Decimate-by-Two Filter

This block low-pass filters a complex receive stream and halves its sample rate. It is placed behind an integrating-comb decimator in a down-conversion chain, so the overall decimation of the chain is the comb rate multiplied by two. Signed 16-bit I and Q samples arrive with a valid strobe. One filtered I/Q pair leaves, with its own valid strobe, for every second accepted input pair.

The filter has 31 taps with a symmetric response. Every second coefficient is zero, except the centre tap. The centre tap equals 2^15, so that path is a plain shift. For each non-zero offset pair, the two mirrored samples are added before a single multiply. This gives eight multiplies per channel per output, plus the shifted centre term. The sum is kept at full precision, rounded, scaled down by 2^16 and saturated back to 16 bits.

A static bypass input disables the filtering: every accepted sample passes straight through at the input rate, with no low-pass action. Both channels use the same coefficients. They run in two identical, independent datapaths that share one controller.

Top module: `halfband_decim2`

## Requirements
- R1: While `rst` is high and after it is released, `outValid` is 0 and `outI`/`outQ` are 0. Reset also clears the delay line, the phase toggle and the fill count, so the first filtered output after a reset again comes on the 31st accepted sample.
- R2: In filter mode, each output is taken over the 31 most recent accepted samples x[0..30], where x[0] is the newest. The output equals round(S / 65536), with S = 32768·x[15] + Σ c(k)·(x[15−k] + x[15+k]) for odd k from 1 to 15. The weights are c(1)=20585, c(3)=−6158, c(5)=2950, c(7)=−1468, c(9)=970, c(11)=−645, c(13)=380, c(15)=−166. All taps at even non-zero offsets from the centre are 0.
- R3: In filter mode, an output is produced when the 31st, 33rd, 35th … accepted sample since reset is taken. Each output is a single-cycle `outValid` pulse, and two filtered pulses never fall in adjacent cycles.
- R4: Rounding adds 2^15 to S and then shifts right arithmetically by 16, which is a floor. For example, a constant input of −1000 settles to −1002.
- R5: A result outside the 16-bit two's-complement range saturates to 32767 or −32768.
- R6: A filtered output is registered on the first clock edge after the edge that accepts its emitting sample, and `outValid` is high for that one cycle.
- R7: Cycles with `inValid` low neither shift the delay line nor advance the phase, and they produce no output.
- R8: I and Q are filtered with the same weights and the same latency. Neither channel's data affects the other.
- R9: With `bypass` high, each accepted sample appears unchanged on `outI`/`outQ` on its accepting edge, with `outValid` high for one cycle per sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bypass | input | 1 | Static: 1 passes samples through unfiltered |
| inValid | input | 1 | Input pair is accepted on this edge |
| inI | input | 16 | In-phase sample, signed |
| inQ | input | 16 | Quadrature sample, signed |
| outValid | output | 1 | Output pair valid for this cycle |
| outI | output | 16 | Filtered or passed in-phase sample, signed |
| outQ | output | 16 | Filtered or passed quadrature sample, signed |

## Verification
The properties assume that `bypass` is static. It may change only while no sample is in flight, and a reset must follow the change, because the controller's phase and fill count are meaningful only within one mode. The stimulus follows this rule: it switches `bypass` only during idle cycles and then resets the block before sending more samples. Inputs may have arbitrary gaps in `inValid`. The stimulus uses both back-to-back runs and irregular gaps so that the output spacing, latency and source checks are all exercised.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

  localparam int COEF_W       = 16;
  localparam int CENTRE_SHIFT = 15;

  typedef struct packed {
    logic shiftEn;  // accept a sample into the delay line
    logic calcEn;   // register the filtered sum this edge
    logic passEn;   // register the raw input this edge
  } hbdStrobe_t;

  // Non-zero weight at offset 2*pairIdx+1 from the centre tap
  function automatic logic signed [COEF_W-1:0] pairCoef(input int pairIdx);
    case (pairIdx)
      0:       return 16'sd20585;
      1:       return -16'sd6158;
      2:       return 16'sd2950;
      3:       return -16'sd1468;
      4:       return 16'sd970;
      5:       return -16'sd645;
      6:       return 16'sd380;
      default: return -16'sd166;
    endcase
  endfunction

endpackage

// File: rtl/hbd_ctrl.sv
module hbd_ctrl
  import hbd_pkg::*;
#(
  parameter int TAPS = 31
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bypass,
  input  logic       inValid,
  output hbdStrobe_t strobe,
  output logic       outValid
);

  localparam int CNT_W = $clog2(TAPS + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(TAPS - 1);

  logic             phase;
  logic [CNT_W-1:0] fillCnt;
  logic             calcReg;
  logic             emitNow;

  // Emit on odd-numbered accepted samples once the window is full
  assign emitNow = inValid && !bypass && !phase && (fillCnt == FULL_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= 1'b0;
      fillCnt  <= '0;
      calcReg  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      if (inValid) begin
        phase <= ~phase;
        if (fillCnt != FULL_CNT) fillCnt <= fillCnt + 1'b1;
      end
      calcReg  <= emitNow;
      outValid <= calcReg || (inValid && bypass);
    end
  end

  assign strobe.shiftEn = inValid;
  assign strobe.calcEn  = calcReg;
  assign strobe.passEn  = inValid && bypass;

endmodule

// File: rtl/hbd_lane.sv
module hbd_lane
  import hbd_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int TAPS      = 31,
  parameter int OUT_SHIFT = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  hbdStrobe_t               strobe,
  input  logic signed [DATA_W-1:0] inSample,
  output logic signed [DATA_W-1:0] outSample
);

  localparam int CENTRE = (TAPS - 1) / 2;
  localparam int PAIRS  = (TAPS + 1) / 4;
  localparam int ACC_W  = DATA_W + 1 + COEF_W + $clog2(PAIRS + 1);
  localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) <<< (OUT_SHIFT - 1);
  localparam logic signed [ACC_W-1:0] MAX_VAL  = (ACC_W'(1) <<< (DATA_W - 1)) - 1;
  localparam logic signed [ACC_W-1:0] MIN_VAL  = -(ACC_W'(1) <<< (DATA_W - 1));

  logic signed [DATA_W-1:0] line [TAPS];
  logic signed [DATA_W:0]   preSum [PAIRS];
  logic signed [ACC_W-1:0]  prod [PAIRS];
  logic signed [ACC_W-1:0]  centreTerm;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  rounded;
  logic signed [DATA_W-1:0] satVal;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < TAPS; t++) line[t] <= '0;
    end else if (strobe.shiftEn) begin
      line[0] <= inSample;
      for (int t = 1; t < TAPS; t++) line[t] <= line[t-1];
    end
  end

  // Mirror pre-add then one multiply per non-zero pair
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    localparam int OFF = 2 * p + 1;
    localparam logic signed [ACC_W-1:0] COEF = ACC_W'(pairCoef(p));
    assign preSum[p] = (DATA_W+1)'(line[CENTRE-OFF]) + (DATA_W+1)'(line[CENTRE+OFF]);
    assign prod[p]   = ACC_W'(preSum[p]) * COEF;
  end

  assign centreTerm = ACC_W'(line[CENTRE]) <<< CENTRE_SHIFT;

  always_comb begin
    acc = centreTerm;
    for (int p = 0; p < PAIRS; p++) acc = acc + prod[p];
  end

  assign rounded = (acc + HALF_LSB) >>> OUT_SHIFT;

  always_comb begin
    if (rounded > MAX_VAL)      satVal = MAX_VAL[DATA_W-1:0];
    else if (rounded < MIN_VAL) satVal = MIN_VAL[DATA_W-1:0];
    else                        satVal = rounded[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)                outSample <= '0;
    else if (strobe.passEn) outSample <= inSample;
    else if (strobe.calcEn) outSample <= satVal;
  end

endmodule

// File: rtl/halfband_decim2.sv
module halfband_decim2
  import hbd_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int TAPS      = 31,
  parameter int OUT_SHIFT = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bypass,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outI,
  output logic signed [DATA_W-1:0] outQ
);

  localparam int CHANNELS = 2;

  hbdStrobe_t               strobe;
  logic signed [DATA_W-1:0] chanIn  [CHANNELS];
  logic signed [DATA_W-1:0] chanOut [CHANNELS];

  assign chanIn[0] = inI;
  assign chanIn[1] = inQ;
  assign outI      = chanOut[0];
  assign outQ      = chanOut[1];

  hbd_ctrl #(.TAPS(TAPS)) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .bypass  (bypass),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_lane
    hbd_lane #(
      .DATA_W   (DATA_W),
      .TAPS     (TAPS),
      .OUT_SHIFT(OUT_SHIFT)
    ) lane_i (
      .clk      (clk),
      .rst      (rst),
      .strobe   (strobe),
      .inSample (chanIn[ch]),
      .outSample(chanOut[ch])
    );
  end

endmodule

// File: rtl/hbd_checker.sv
module hbd_checker #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 31
) (
  input logic              clk,
  input logic              rst,
  input logic              bypass,
  input logic              inValid,
  input logic [DATA_W-1:0] inI,
  input logic [DATA_W-1:0] inQ,
  input logic              outValid,
  input logic [DATA_W-1:0] outI,
  input logic [DATA_W-1:0] outQ
);

  localparam int CNT_W = $clog2(TAPS + 1);
  localparam logic [CNT_W-1:0] FILLED = CNT_W'(TAPS);

  logic [CNT_W-1:0] seenCnt;

  always_ff @(posedge clk) begin
    if (rst)                          seenCnt <= '0;
    else if (inValid && seenCnt != FILLED) seenCnt <= seenCnt + 1'b1;
  end

  // R6: a filtered pulse comes from a sample accepted two sampling edges earlier
  p_filt_source_r6: assert property (@(posedge clk) disable iff (rst)
    (outValid && !bypass) |-> $past(inValid, 2));

  // R3: filtered pulses are never adjacent
  p_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    (outValid && !bypass) |=> !outValid);

  // R3: no filtered output before the window holds 31 samples
  p_fill_r3: assert property (@(posedge clk) disable iff (rst)
    (outValid && !bypass) |-> (seenCnt == FILLED));

  // R9: bypass copies the accepted pair unchanged
  p_pass_copy_r9: assert property (@(posedge clk) disable iff (rst)
    (outValid && bypass) |-> ($past(inValid) && outI == $past(inI) && outQ == $past(inQ)));

  // R7: two idle input cycles leave no output pulse
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(inValid) && !$past(inValid, 2)) |-> !outValid);

endmodule

bind halfband_decim2 hbd_checker #(.DATA_W(DATA_W), .TAPS(TAPS)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .bypass  (bypass),
  .inValid (inValid),
  .inI     (inI),
  .inQ     (inQ),
  .outValid(outValid),
  .outI    (outI),
  .outQ    (outQ)
);

// File: tb/halfband_decim2_tb_top.sv
`timescale 1ns/1ps
module halfband_decim2_tb_top;

  typedef struct {
    int    iVal;
    int    qVal;
    int    cyc;
    string req;
  } expect_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bypass = 1'b0;
  logic              inValid = 1'b0;
  logic signed [15:0] inI = '0;
  logic signed [15:0] inQ = '0;
  logic              outValid;
  logic signed [15:0] outI;
  logic signed [15:0] outQ;

  int      checks = 0;
  int      errors = 0;
  int      cyc = 0;
  int      accepted = 0;
  int      pushed = 0;
  int      seen = 0;
  int      lfsr = 16'hACE1;
  longint  histI [31];
  longint  histQ [31];
  expect_t expQ [$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  halfband_decim2 dut_i (
    .clk(clk), .rst(rst), .bypass(bypass), .inValid(inValid),
    .inI(inI), .inQ(inQ), .outValid(outValid), .outI(outI), .outQ(outQ)
  );

  function automatic longint tapWeight(input int off);
    case (off)
      1: return 20585;   3: return -6158;  5: return 2950;  7: return -1468;
      9: return 970;    11: return -645;  13: return 380;  15: return -166;
      default: return 0;
    endcase
  endfunction

  function automatic int model(input longint w [31]);
    longint acc;
    longint r;
    acc = w[15] * 32768;
    for (int k = 1; k <= 15; k += 2) acc += tapWeight(k) * (w[15-k] + w[15+k]);
    r = (acc + 32768) >>> 16;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  function automatic int nextLfsr();
    lfsr = (lfsr & 1) ? ((lfsr >> 1) ^ 16'hB400) : (lfsr >> 1);
    return lfsr;
  endfunction

  task automatic check(input string req, input int act, input int exp_v, input string what);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  // Output monitor: compares every pulse with the model, including its cycle
  always @(negedge clk) begin
    if (!rst && outValid) begin
      seen++;
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3 unexpected output actual=%0d expected=none", outI);
      end else begin
        expect_t e;
        e = expQ.pop_front();
        check(e.req, int'(outI), e.iVal, "outI");
        check(e.req, int'(outQ), e.qVal, "outQ");
        check("R6", cyc, e.cyc, "output cycle");
      end
    end
  end

  task automatic pushSample(input int iv, input int qv, input string req);
    int acceptEdge;
    expect_t e;
    inValid = 1'b1;
    inI = 16'(iv);
    inQ = 16'(qv);
    acceptEdge = cyc + 1;
    if (bypass) begin
      e.iVal = int'($signed(16'(iv))); e.qVal = int'($signed(16'(qv)));
      e.cyc = acceptEdge; e.req = req;
      expQ.push_back(e); pushed++;
    end else begin
      for (int t = 30; t > 0; t--) begin histI[t] = histI[t-1]; histQ[t] = histQ[t-1]; end
      histI[0] = longint'($signed(16'(iv)));
      histQ[0] = longint'($signed(16'(qv)));
      accepted++;
      if (accepted >= 31 && (accepted % 2) == 1) begin
        e.iVal = model(histI); e.qVal = model(histQ);
        e.cyc = acceptEdge + 1; e.req = req;
        expQ.push_back(e); pushed++;
      end
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic idle(input int n);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    accepted = 0;
    for (int t = 0; t < 31; t++) begin histI[t] = 0; histQ[t] = 0; end
    expQ.delete();
    pushed = 0;
    seen = 0;
  endtask

  task automatic drain(input string req);
    idle(4);
    check(req, seen, pushed, "output count");
  endtask

  task automatic testReset();
    doReset();
    idle(1);
    check("R1", int'(outValid), 0, "outValid after reset");
    check("R1", int'(outI), 0, "outI after reset");
    check("R1", int'(outQ), 0, "outQ after reset");
  endtask

  // Impulse on I at sample 31 (odd offsets), on Q at sample 32 (centre path)
  task automatic testImpulse();
    doReset();
    for (int n = 1; n <= 64; n++)
      pushSample(n == 31 ? 30000 : 0, n == 32 ? -30000 : 0, "R2");
    drain("R2");
    check("R8", seen, 17, "impulse output count");
  endtask

  task automatic testSaturate();
    doReset();
    for (int n = 1; n <= 40; n++) pushSample(32767, -32768, "R5");
    drain("R5");
    check("R5", int'(outI), 32767, "positive clamp");
    check("R5", int'(outQ), -32768, "negative clamp");
  endtask

  task automatic testRound();
    doReset();
    for (int n = 1; n <= 35; n++) pushSample(1000, -1000, "R4");
    drain("R4");
    check("R4", int'(outI), 1002, "rounded +1000 DC");
    check("R4", int'(outQ), -1002, "rounded -1000 DC");
  endtask

  task automatic testStream();
    doReset();
    for (int n = 1; n <= 80; n++) begin
      int a;
      int b;
      a = nextLfsr();
      b = nextLfsr();
      pushSample(a, b, "R3");
    end
    drain("R3");
    check("R3", seen, 25, "outputs for 80 samples");
  endtask

  task automatic testGaps();
    doReset();
    for (int n = 1; n <= 70; n++) begin
      int a;
      int b;
      a = nextLfsr();
      b = nextLfsr();
      pushSample(a, b, "R7");
      idle(n % 4);
    end
    drain("R7");
    check("R7", seen, 20, "outputs for 70 gapped samples");
  endtask

  task automatic testBypass();
    idle(2);
    bypass = 1'b1;
    doReset();
    for (int n = 1; n <= 12; n++) begin
      pushSample(n * 2711 - 20000, -n * 1999, "R9");
      idle(n % 3);
    end
    drain("R9");
    bypass = 1'b0;
    idle(2);
  endtask

  task automatic testMidReset();
    doReset();
    for (int n = 1; n <= 21; n++) pushSample(n * 100, -n * 50, "R1");
    doReset();
    for (int n = 1; n <= 34; n++) pushSample(500 - n * 13, n * 77, "R1");
    drain("R1");
    check("R1", seen, 2, "outputs after mid-stream reset");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testImpulse();
    testSaturate();
    testRound();
    testStream();
    testGaps();
    testBypass();
    testMidReset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule